// File: doc/BRIEF.md
# UART Bit-Rate Timer with Fixed Prescaler

This block derives the bit-rate timing of a serial port from the system clock. The clock first passes a fixed divide-by-32 prescaler. A programmable divider then counts prescaler strobes. The divider value is put together from a high-byte register and a low-byte register. The result is a one-cycle tick for every bit period, so the tick rate equals the clock frequency divided by 32 times the divider value.

Software programs the timer through a small byte-wide register port. A control register holds a clock-select bit, and the timer runs only while that bit picks the internal timer. A new divider value written while the timer runs is held back until the period in progress has ended. Each period therefore uses either the old value or the new one, never a mix of the two.

Top module: `uart_baud_timer`

## Requirements
- R1: A synchronous active-low reset clears the high-byte register, the low-byte register and the clock-select bit. While reset is held, `baud_tick` stays low.
- R2: A write takes effect on the clock edge where `wr_en` is high. The address selects the target: 0 is the divider high byte, 1 is the divider low byte, and 2 is the control register, whose bit 0 is the clock-select bit. Address 3 is ignored.
- R3: `rd_data` shows the register at `addr` combinationally. Address 2 returns the clock-select bit in bit 0 with zeros above it. Address 3 returns zero.
- R4: While the block is enabled, ticks are spaced exactly 32 × D clock cycles apart. D is the 16-bit value {high byte, low byte}.
- R5: `baud_tick` is high for exactly one clock cycle per period.
- R6: A divider value of 0 acts as 2^(2·BYTE_W), which is 65536 at the default width.
- R7: A divider value written during a period does not change that period. It takes effect at the next period boundary.
- R8: While the clock-select bit is 0, no tick appears and the prescaler and divider counters are held at zero. After the bit is written to 1, the first tick appears 32 × D cycles after the write edge.
- R9: With D = 130 (high byte 0x00, low byte 0x82), which is the setting for 19200 baud from an 80 MHz clock, the tick period is 4160 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | BYTE_W (8) | Write data |
| rd_data | output | BYTE_W (8) | Read data of the addressed register |
| baud_tick | output | 1 | One-cycle pulse, once per bit period |

## Verification
A register write can land in the same cycle in which the divider finishes a period and reloads. The bench provokes this by rewriting the divider bytes right after a tick, with random values taken from a fixed seed. It then checks that the next tick interval still uses the old value and that the interval after it uses the new one. Disabling the timer while it runs also competes with the counters advancing. This case is judged by the absence of ticks over a long window and by the exact delay of the first tick after the timer is enabled again.

// File: rtl/baud_timer_pkg.sv
// Shared register addresses of the bit-rate timer.
// Assumes a 2-bit register address space.
package baud_timer_pkg;
    typedef enum logic [1:0] {
        REG_DIV_HI = 2'd0,
        REG_DIV_LO = 2'd1,
        REG_CTRL   = 2'd2,
        REG_NONE   = 2'd3
    } baud_reg_e;
endpackage

// File: rtl/baud_regs.sv
// Register file: divider high and low bytes plus the clock-select bit.
// Assumes single-cycle writes and combinational read-back.
module baud_regs
    import baud_timer_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [DIV_W-1:0]  div_q,
    output logic              en_q
);
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] lo_q;

    // Store a write into the register picked by the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
            en_q <= 1'b0;
        end else if (wr_en) begin
            case (baud_reg_e'(addr))
                REG_DIV_HI: hi_q <= wr_data;
                REG_DIV_LO: lo_q <= wr_data;
                REG_CTRL:   en_q <= wr_data[0];
                default:    ;
            endcase
        end
    end

    // Return the addressed register.
    always_comb begin
        case (baud_reg_e'(addr))
            REG_DIV_HI: rd_data = hi_q;
            REG_DIV_LO: rd_data = lo_q;
            REG_CTRL:   rd_data = {{(BYTE_W-1){1'b0}}, en_q};
            default:    rd_data = '0;
        endcase
    end

    assign div_q = {hi_q, lo_q};
endmodule

// File: rtl/baud_prescaler.sv
// Fixed power-of-two prescaler: one strobe every 2**PRE_W enabled cycles.
// Assumes the counter restarts from zero whenever the enable is low.
module baud_prescaler #(
    parameter int PRE_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic pre_strobe
);
    logic [PRE_W-1:0] cnt_q;

    // Free-running count while enabled, held at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assign pre_strobe = en && (cnt_q == {PRE_W{1'b1}});
endmodule

// File: rtl/baud_divider.sv
// Programmable divider of prescaler strobes. It takes a new value only at
// a period boundary or while disabled. A value of 0 counts 2**DIV_W strobes.
module baud_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pre_strobe,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] act_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_val;
    logic             at_end;

    assign last_val = act_q - 1'b1;   // wraps so that 0 means 2**DIV_W
    assign at_end   = (cnt_q == last_val);
    assign tick     = en && pre_strobe && at_end;

    // Count strobes and reload the active value at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
            act_q <= div_in;
        end else if (pre_strobe) begin
            if (at_end) begin
                cnt_q <= '0;
                act_q <= div_in;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_baud_timer.sv
// Top of the bit-rate timer: registers, prescaler and divider.
// Assumes one clock domain with a synchronous active-low reset.
module uart_baud_timer #(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              baud_tick
);
    logic [DIV_W-1:0] div_val;
    logic             sel_en;
    logic             pre_strobe;

    baud_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .div_q   (div_val),
        .en_q    (sel_en)
    );

    baud_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (sel_en),
        .pre_strobe (pre_strobe)
    );

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (sel_en),
        .pre_strobe (pre_strobe),
        .div_in     (div_val),
        .tick       (baud_tick)
    );
endmodule

// File: rtl/baud_timer_checker.sv
// Assertion checker for uart_baud_timer, attached by bind.
module baud_timer_checker
    import baud_timer_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5,
    localparam int DIV_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [DIV_W-1:0]  div_q,
    input logic              baud_tick
);
    logic [31:0] gap_q;

    // Enabled cycles since enable or since the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  gap_q <= '0;
        else if (baud_tick) gap_q <= '0;
        else                gap_q <= gap_q + 1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (div_q == '0 && !en && !baud_tick));

    a_r2_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIV_HI) |=> div_q[DIV_W-1:BYTE_W] == $past(wr_data));

    a_r2_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIV_LO) |=> div_q[BYTE_W-1:0] == $past(wr_data));

    a_r4_prescale_multiple: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> gap_q[PRE_W-1:0] == {PRE_W{1'b1}});

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !baud_tick);
endmodule

bind uart_baud_timer baud_timer_checker #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (sel_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .div_q     (div_val),
    .baud_tick (baud_tick)
);

// File: tb/test_uart_baud_timer.sv
module test_uart_baud_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       baud_tick;

    // narrow instance for the zero-divider case
    logic       s_wr_en = 1'b0;
    logic [1:0] s_addr = 2'd0;
    logic [3:0] s_wr_data = 4'd0;
    logic [3:0] s_rd_data;
    logic       s_tick;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int nticks = 0, tick_cyc = 0, last_gap = 0;
    int s_nticks = 0, s_tick_cyc = 0;
    int wr_cyc = 0;
    bit done = 0;

    uart_baud_timer i_uart_baud_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .baud_tick(baud_tick)
    );

    uart_baud_timer #(.BYTE_W(4)) i_small (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .addr(s_addr),
        .wr_data(s_wr_data), .rd_data(s_rd_data), .baud_tick(s_tick)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (baud_tick) begin
            last_gap = cyc - tick_cyc;
            tick_cyc = cyc;
            nticks++;
        end
        if (s_tick) begin
            s_tick_cyc = cyc;
            s_nticks++;
        end
    end

    function automatic int exp_period(int d, int bw);
        return 32 * ((d == 0) ? (1 << (2 * bw)) : d);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d; wr_cyc = cyc;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_ticks(input int target);
        while (nticks < target) @(posedge clk);
    endtask

    initial begin
        int v, prev, d, base;
        repeat (4) @(posedge clk);
        #1;
        chk(baud_tick == 1'b0, "R1 tick low in reset", baud_tick, 0);
        @(negedge clk) rst_n = 1'b1;
        rd(2'd0, v); chk(v == 0, "R1 hi cleared", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 lo cleared", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 select cleared", v, 0);

        // R2/R3 register writes and read-back
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h82);
        wr(2'd3, 8'hFF);
        rd(2'd0, v); chk(v == 8'h00, "R3 hi readback", v, 0);
        rd(2'd1, v); chk(v == 8'h82, "R2 lo readback", v, 8'h82);
        rd(2'd3, v); chk(v == 0, "R3 unused address reads zero", v, 0);
        rd(2'd2, v); chk(v == 0, "R2 select still off", v, 0);

        // R8/R9 enable, first tick, steady period
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk(v == 1, "R3 select readback", v, 1);
        wait_ticks(1);
        chk(tick_cyc - wr_cyc == exp_period(130, 8), "R8 first tick delay", tick_cyc - wr_cyc, 4160);
        @(negedge clk); #1;
        chk(baud_tick == 1'b0, "R5 tick one cycle", baud_tick, 0);
        wait_ticks(2);
        chk(last_gap == 4160, "R9 period at 0x0082", last_gap, 4160);

        // R7 update mid-stream takes effect at the next boundary
        wr(2'd1, 8'h10);
        wait_ticks(3);
        chk(last_gap == exp_period(130, 8), "R7 old period kept", last_gap, 4160);
        wait_ticks(4);
        chk(last_gap == exp_period(16, 8), "R7 new period applied", last_gap, 512);

        // R4 random divider values, fixed seed
        prev = 16;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 4; i++) begin
            d = $urandom_range(300, 1);
            base = nticks;
            wr(2'd0, 8'(d >> 8));
            wr(2'd1, 8'(d));
            wait_ticks(base + 1);
            chk(last_gap == exp_period(prev, 8), "R4 gap before reload", last_gap, exp_period(prev, 8));
            wait_ticks(base + 2);
            chk(last_gap == exp_period(d, 8), "R4 gap after reload", last_gap, exp_period(d, 8));
            prev = d;
        end

        // R8 disable suppresses ticks, then restart from zero
        wr(2'd2, 8'h00);
        base = nticks;
        repeat (3000) @(posedge clk);
        chk(nticks == base, "R8 no tick while off", nticks - base, 0);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h01);
        wait_ticks(base + 1);
        chk(tick_cyc - wr_cyc == exp_period(5, 8), "R8 restart delay", tick_cyc - wr_cyc, 160);

        // R6 zero divider on the narrow instance
        @(negedge clk);
        s_wr_en = 1'b1; s_addr = 2'd2; s_wr_data = 4'h1; wr_cyc = cyc;
        @(negedge clk);
        s_wr_en = 1'b0;
        while (s_nticks < 1) @(posedge clk);
        chk(s_tick_cyc - wr_cyc == exp_period(0, 4), "R6 zero acts as full range", s_tick_cyc - wr_cyc, 8192);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule